// File: doc/BRIEF.md
# Certificate Stream Capture Buffer

This block takes a certificate delivered as a stream of 16-bit beats and stores it in an on-chip dual-port RAM. Each beat has a valid strobe, a 2-bit byte enable and a last marker. Software first programs a starting halfword address. A write-address counter then places each valid beat at the counter's current value and advances by one halfword.

When the beat marked last is stored, a sticky ready flag rises. Software polls this flag and clears it before it arms the next capture. Software then reads the stored bytes 32 bits at a time through a 4 KB window in the register space. The window packs two consecutive halfwords into each word.

The register port addresses 32-bit words. The port shares one address between writes and read requests. Every read request returns its data exactly one cycle later, whatever the target.

Top module: `cert_capture_top`

## Requirements
- R1: After reset the ready flag is 0, the write-address counter is 0 and reg_rd_valid is low.
- R2: A register write to word address 0x000 loads the counter from reg_wr_data[11:1]. Bits [7:1] are gated by reg_wr_be[0] and bits [11:8] by reg_wr_be[1]. A read of word 0x000 returns the counter in bits [11:1], with every other bit 0.
- R3: Each cycle with cs_valid high stores the beat at the counter's current value, and the counter then advances by one. Without cs_valid and without a load, the counter holds its value.
- R4: cs_be[0] writes cs_data[7:0] to the low byte of the addressed halfword, and cs_be[1] writes cs_data[15:8] to the high byte. A byte whose enable is 0 keeps its previous contents, so an odd-length certificate ends with a beat that has only cs_be[0] set.
- R5: A valid beat with cs_last high sets the ready flag, and the flag stays set until software writes it. If the last beat and a software write of 0 land in the same cycle, the flag ends up 1.
- R6: A register write to word 0x001 with reg_wr_be[0] set loads the ready flag from reg_wr_data[0]. A read of word 0x001 returns the flag in bit 0.
- R7: Word addresses 0x400 to 0x7FF form the RAM window. Word index i returns halfword 2i in bits [15:0] and halfword 2i+1 in bits [31:16]. reg_rd_valid is high exactly in the cycle after each reg_rd_req.
- R8: A start-address write made while beats are arriving overrides the counter from the next cycle on. The beat in the cycle of the write still goes to the old address.
- R9: The counter wraps from 2047 to 0 without any indication.
- R10: A read of any other word address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_valid | input | 1 | Certificate beat valid |
| cs_be | input | 2 | Byte enables of the beat |
| cs_data | input | 16 | Beat data |
| cs_last | input | 1 | Final beat of the certificate |
| reg_addr | input | 11 | Register word address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_wr_be | input | 4 | Register write byte enables |
| reg_rd_req | input | 1 | Register read request |
| reg_rd_valid | output | 1 | Read data valid, one cycle after the request |
| reg_rd_data | output | 32 | Read data |

## Verification
The bench builds the block with its default halfword address width of 11, which gives a 2048-halfword RAM and the full 4 KB window. At this width the counter can be loaded to 2047, so the wrap back to halfword 0 and the matching readback from the top and bottom window words are within reach. A table of mixed byte-enable beats, written over a known background, checks byte preservation halfword by halfword. Directed cases place a start-address write in the middle of a capture and land a ready-flag clear in the same cycle as a last beat.

// File: rtl/cert_pkg.sv
package cert_pkg;

    // Word offsets of the control registers inside the register space
    localparam int unsigned OFS_START = 0;
    localparam int unsigned OFS_READY = 1;

    // Registered state of the register front end
    typedef struct packed {
        logic        ready;
        logic        rd_valid;
        logic        sel_ram;
        logic [31:0] csr_rdata;
    } regif_state_t;

endpackage

// File: rtl/cert_wr_addr.sv
module cert_wr_addr #(
    parameter int unsigned HW_AW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [HW_AW-1:0] ld_mask,
    input  logic [HW_AW-1:0] ld_val,
    input  logic             beat_valid,
    output logic [HW_AW-1:0] addr_q
);

    typedef struct packed {
        logic [HW_AW-1:0] addr;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (ld_en) begin
            state_d.addr = (state_q.addr & ~ld_mask) | (ld_val & ld_mask);
        end else if (beat_valid) begin
            state_d.addr = state_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign addr_q = state_q.addr;

    // R3
    inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !ld_en) |=> (addr_q == HW_AW'($past(addr_q) + 1'b1)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && !ld_en) |=> $stable(addr_q));

    // R8
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && (ld_mask == '1)) |=> (addr_q == $past(ld_val)));

endmodule

// File: rtl/cert_dpram.sv
module cert_dpram #(
    parameter int unsigned HW_AW = 11
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [HW_AW-1:0] wr_addr,
    input  logic [1:0]       wr_be,
    input  logic [15:0]      wr_data,
    input  logic             rd_en,
    input  logic [HW_AW-2:0] rd_addr,
    output logic [31:0]      rd_data
);

    localparam int unsigned ROWS = 1 << (HW_AW - 1);

    logic [HW_AW-2:0] wr_row;
    assign wr_row = wr_addr[HW_AW-1:1];

    // Two halfword banks (even/odd address), each split into two byte lanes
    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar l = 0; l < 2; l++) begin : g_lane
            logic [7:0] mem [ROWS];
            logic [7:0] rd_byte_q;

            always_ff @(posedge clk) begin
                if (wr_en && (wr_addr[0] == 1'(b)) && wr_be[l]) begin
                    mem[wr_row] <= wr_data[8*l +: 8];
                end
                if (rd_en) begin
                    rd_byte_q <= mem[rd_addr];
                end
            end

            assign rd_data[16*b + 8*l +: 8] = rd_byte_q;
        end
    end

endmodule

// File: rtl/cert_reg_decode.sv
module cert_reg_decode
    import cert_pkg::*;
#(
    parameter int unsigned HW_AW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HW_AW-1:0] reg_addr,
    input  logic             reg_wr_en,
    input  logic [31:0]      reg_wr_data,
    input  logic [3:0]       reg_wr_be,
    input  logic             reg_rd_req,
    input  logic             cs_valid,
    input  logic             cs_last,
    input  logic [HW_AW-1:0] cnt_q,
    output logic             ld_en,
    output logic [HW_AW-1:0] ld_mask,
    output logic [HW_AW-1:0] ld_val,
    output logic             ram_rd_en,
    output logic [HW_AW-2:0] ram_rd_addr,
    input  logic [31:0]      ram_rd_data,
    output logic             reg_rd_valid,
    output logic [31:0]      reg_rd_data
);

    localparam int unsigned WORD_AW = HW_AW - 1;

    regif_state_t state_d, state_q;

    logic hit_start, hit_ready, hit_ram, ready_wr, last_beat;
    logic unused_ok;

    assign hit_ram   = reg_addr[HW_AW-1];
    assign hit_start = (reg_addr == HW_AW'(OFS_START));
    assign hit_ready = (reg_addr == HW_AW'(OFS_READY));
    assign ready_wr  = reg_wr_en && hit_ready && reg_wr_be[0];
    assign last_beat = cs_valid && cs_last;

    // Start field sits at bits [HW_AW:1]; each bit follows its byte lane enable
    for (genvar i = 0; i < HW_AW; i++) begin : g_mask
        assign ld_mask[i] = reg_wr_be[(i + 1) / 8];
    end
    assign ld_val = reg_wr_data[HW_AW:1];
    assign ld_en  = reg_wr_en && hit_start && (|ld_mask);

    assign ram_rd_en   = reg_rd_req && hit_ram;
    assign ram_rd_addr = reg_addr[WORD_AW-1:0];

    assign unused_ok = ^{reg_wr_data, reg_wr_be};

    always_comb begin
        state_d = state_q;

        if (last_beat) begin
            state_d.ready = 1'b1;
        end else if (ready_wr) begin
            state_d.ready = reg_wr_data[0];
        end

        state_d.rd_valid  = reg_rd_req;
        state_d.sel_ram   = reg_rd_req && hit_ram;
        state_d.csr_rdata = '0;
        if (reg_rd_req && hit_start) begin
            state_d.csr_rdata = {{(31 - HW_AW){1'b0}}, cnt_q, 1'b0};
        end else if (reg_rd_req && hit_ready) begin
            state_d.csr_rdata = {31'd0, state_q.ready};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_rd_valid = state_q.rd_valid;
    assign reg_rd_data  = state_q.sel_ram ? ram_rd_data : state_q.csr_rdata;

    // R5
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> state_q.ready);

    // R5
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!last_beat && !ready_wr) |=> $stable(state_q.ready));

    // R7
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_req |=> reg_rd_valid);

    // R7
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_req |=> !reg_rd_valid);

    // R10
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_req && !hit_ram && !hit_start && !hit_ready) |=> (reg_rd_data == '0));

endmodule

// File: rtl/cert_capture_top.sv
module cert_capture_top #(
    parameter int unsigned HW_AW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_valid,
    input  logic [1:0]       cs_be,
    input  logic [15:0]      cs_data,
    input  logic             cs_last,
    input  logic [HW_AW-1:0] reg_addr,
    input  logic             reg_wr_en,
    input  logic [31:0]      reg_wr_data,
    input  logic [3:0]       reg_wr_be,
    input  logic             reg_rd_req,
    output logic             reg_rd_valid,
    output logic [31:0]      reg_rd_data
);

    logic             ld_en;
    logic [HW_AW-1:0] ld_mask, ld_val, cnt_q;
    logic             ram_rd_en;
    logic [HW_AW-2:0] ram_rd_addr;
    logic [31:0]      ram_rd_data;

    cert_reg_decode #(.HW_AW(HW_AW)) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_data  (reg_wr_data),
        .reg_wr_be    (reg_wr_be),
        .reg_rd_req   (reg_rd_req),
        .cs_valid     (cs_valid),
        .cs_last      (cs_last),
        .cnt_q        (cnt_q),
        .ld_en        (ld_en),
        .ld_mask      (ld_mask),
        .ld_val       (ld_val),
        .ram_rd_en    (ram_rd_en),
        .ram_rd_addr  (ram_rd_addr),
        .ram_rd_data  (ram_rd_data),
        .reg_rd_valid (reg_rd_valid),
        .reg_rd_data  (reg_rd_data)
    );

    cert_wr_addr #(.HW_AW(HW_AW)) u_wr_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .ld_mask    (ld_mask),
        .ld_val     (ld_val),
        .beat_valid (cs_valid),
        .addr_q     (cnt_q)
    );

    cert_dpram #(.HW_AW(HW_AW)) u_ram (
        .clk     (clk),
        .wr_en   (cs_valid),
        .wr_addr (cnt_q),
        .wr_be   (cs_be),
        .wr_data (cs_data),
        .rd_en   (ram_rd_en),
        .rd_addr (ram_rd_addr),
        .rd_data (ram_rd_data)
    );

endmodule

// File: tb/cert_capture_top_bench.sv
module cert_capture_top_bench;

    localparam int unsigned HW_AW   = 11;
    localparam logic [10:0] A_START = 11'h000;
    localparam logic [10:0] A_READY = 11'h001;
    localparam logic [10:0] A_RAM   = 11'h400;

    typedef struct packed {
        logic [1:0]  be;
        logic [15:0] data;
        logic        last;
        logic [15:0] expv;
    } vec_t;

    // Background 0xA5A5 is written first; expv is the halfword after the beat
    localparam vec_t VECS [8] = '{
        '{2'b11, 16'h1234, 1'b0, 16'h1234},
        '{2'b01, 16'h5678, 1'b0, 16'hA578},
        '{2'b10, 16'h9ABC, 1'b0, 16'h9AA5},
        '{2'b00, 16'hFFFF, 1'b0, 16'hA5A5},
        '{2'b11, 16'h0F0F, 1'b0, 16'h0F0F},
        '{2'b11, 16'hCAFE, 1'b0, 16'hCAFE},
        '{2'b10, 16'hBE00, 1'b0, 16'hBEA5},
        '{2'b01, 16'h00EF, 1'b1, 16'hA5EF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_valid = 1'b0;
    logic [1:0]  cs_be = '0;
    logic [15:0] cs_data = '0;
    logic        cs_last = 1'b0;
    logic [10:0] reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [3:0]  reg_wr_be = '0;
    logic        reg_rd_req = 1'b0;
    logic        reg_rd_valid;
    logic [31:0] reg_rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    cert_capture_top #(.HW_AW(HW_AW)) u_cert_capture_top (
        .clk(clk), .rst_n(rst_n),
        .cs_valid(cs_valid), .cs_be(cs_be), .cs_data(cs_data), .cs_last(cs_last),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_wr_be(reg_wr_be), .reg_rd_req(reg_rd_req),
        .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr_data = d; reg_wr_be = 4'hF; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [10:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        reg_addr = a; reg_rd_req = 1'b1;
        @(negedge clk);
        reg_rd_req = 1'b0;
        d = reg_rd_data;
        v = reg_rd_valid;
    endtask

    task automatic beat(input logic [1:0] be, input logic [15:0] d, input logic last);
        @(negedge clk);
        cs_valid = 1'b1; cs_be = be; cs_data = d; cs_last = last;
        @(negedge clk);
        cs_valid = 1'b0; cs_last = 1'b0;
    endtask

    // Reads back the halfword at halfword address h through the window
    task automatic read_half(input int h, output logic [15:0] hv);
        logic [31:0] w;
        logic v;
        reg_read(A_RAM | 11'(h >> 1), w, v);
        hv = h[0] ? w[31:16] : w[15:0];
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic        v;
        logic [15:0] hv;

        repeat (3) @(negedge clk);
        // R1: outputs during reset and state right after
        check("R1 rd_valid", {31'd0, reg_rd_valid}, 32'd0);
        rst_n = 1'b1;
        reg_read(A_READY, d, v);
        check("R1 ready", d, 32'd0);
        reg_read(A_START, d, v);
        check("R1 counter", d, 32'd0);

        // R6: software sets and clears the flag
        reg_write(A_READY, 32'd1);
        reg_read(A_READY, d, v);
        check("R6 set", d, 32'd1);
        reg_write(A_READY, 32'd0);
        reg_read(A_READY, d, v);
        check("R6 clear", d, 32'd0);

        // R7: valid exactly one cycle after the request
        reg_read(A_START, d, v);
        check("R7 valid", {31'd0, v}, 32'd1);
        @(negedge clk);
        check("R7 valid drop", {31'd0, reg_rd_valid}, 32'd0);

        // Background fill, then table stream from halfword 0x10 (R2 load)
        reg_write(A_START, 32'h10 << 1);
        for (int k = 0; k < 8; k++) beat(2'b11, 16'hA5A5, 1'b0);
        reg_write(A_START, 32'h10 << 1);
        for (int k = 0; k < 8; k++) beat(VECS[k].be, VECS[k].data, VECS[k].last);

        reg_read(A_READY, d, v);
        check("R5 last sets ready", d, 32'd1);
        reg_read(A_START, d, v);
        check("R3 R2 counter after 8 beats", d, 32'h18 << 1);

        // R4 R7: byte-enable results read back per halfword
        for (int k = 0; k < 8; k++) begin
            read_half(16'h10 + k, hv);
            check("R4 R7 halfword", {16'd0, hv}, {16'd0, VECS[k].expv});
        end

        // R5: last beat and software clear in the same cycle
        reg_write(A_READY, 32'd0);
        @(negedge clk);
        cs_valid = 1'b1; cs_be = 2'b11; cs_data = 16'h7777; cs_last = 1'b1;
        reg_addr = A_READY; reg_wr_data = 32'd0; reg_wr_be = 4'hF; reg_wr_en = 1'b1;
        @(negedge clk);
        cs_valid = 1'b0; cs_last = 1'b0; reg_wr_en = 1'b0;
        reg_read(A_READY, d, v);
        check("R5 set wins", d, 32'd1);

        // R9: wrap from 2047 to 0
        reg_write(A_START, 32'h7FF << 1);
        beat(2'b11, 16'h1111, 1'b0);
        beat(2'b11, 16'h2222, 1'b0);
        read_half(2047, hv);
        check("R9 top halfword", {16'd0, hv}, 32'h1111);
        read_half(0, hv);
        check("R9 wrapped halfword", {16'd0, hv}, 32'h2222);
        reg_read(A_START, d, v);
        check("R9 counter", d, 32'h1 << 1);

        // R8: start write in the middle of a capture
        reg_write(A_START, 32'h40 << 1);
        @(negedge clk);
        cs_valid = 1'b1; cs_be = 2'b11; cs_data = 16'h3333;
        @(negedge clk);
        cs_data = 16'h4444;
        reg_addr = A_START; reg_wr_data = 32'h100 << 1; reg_wr_be = 4'hF; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; cs_data = 16'h5555;
        @(negedge clk);
        cs_valid = 1'b0;
        reg_read(A_RAM | 11'h20, d, v);
        check("R8 old address beats", d, 32'h4444_3333);
        read_half(16'h100, hv);
        check("R8 new address beat", {16'd0, hv}, 32'h5555);
        reg_read(A_START, d, v);
        check("R8 counter", d, 32'h101 << 1);

        // R10: unmapped word
        reg_read(11'h005, d, v);
        check("R10 unmapped", d, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule